// File: doc/BRIEF.md
# Cascadable Dual 8-bit Timer

This block provides two 8-bit up-counters that share one free-running prescaler and one small register port. Each channel picks where its count pulses come from: one of three divided versions of the system clock, edges seen on its own external clock pin, or a link to the other channel. Through that link, channel 0 can count the wraps of channel 1, and channel 1 can count the compare-A hits of channel 0, which together form a wider timer.

Each channel compares its counter against two registers, A and B. It can reset its count on either match or on a rising edge of its external reset pin. Three sticky event flags (wrap, match A, match B) each drive an interrupt request line when that line's enable bit is set. Software clears a flag by writing 0 to it.

Top module: `dtmr_top`

## Requirements
- R1: Register map: reg_addr[3] selects the channel, and reg_addr[2:0] selects 0 = control, 1 = status, 2 = compare A, 3 = compare B, 4 = counter; offsets 5 to 7 read as 0x00. A read returns data on reg_rdata one clock after reg_addr is presented. After reset, control and status read 0x00, both compare registers read 0xFF and the counter reads 0x00. Every control value written reads back unchanged.
- R2: Control bits, MSB first: [7] match-B interrupt enable, [6] match-A interrupt enable, [5] wrap interrupt enable, [4:3] clear source, [2:0] count source. Count source 000 holds the counter still.
- R3: Count sources 001, 010 and 011 add exactly one count for every 8, 64 and 8192 system clocks respectively.
- R4: Count source 101 counts rising edges of the channel's ext_clk, 110 counts falling edges and 111 counts both. A count registers a few clocks after the edge, once the pin has passed its synchronizer.
- R5: Count source 100 is the cascade: channel 0 advances once per wrap of channel 1, and channel 1 advances once per match-A event of channel 0.
- R6: When both channels select 100 at once, no cascade pulse reaches either channel, even if a register write creates a match on channel 0.
- R7: Clear source 00 never clears. 01 clears on match A, 10 clears on match B, 11 clears on a rising edge of the channel's ext_rst pin. With 00 selected, an ext_rst edge has no effect.
- R8: Status bit 0 (wrap) sets when the counter steps from 0xFF to 0x00. Bit 1 and bit 2 set when the counter becomes equal to compare A or compare B, including when the equality is caused by a register write. Flags hold until a status write puts 0 in their bit. Writing 1 leaves a flag unchanged, and a new event wins over a clear in the same cycle.
- R9: If a clear and a count pulse arrive in the same cycle, the counter becomes 0x00.
- R10: irq_ovf, irq_cma and irq_cmb of a channel equal status bit 0, 1 and 2 ANDed with control bit 5, 6 and 7, registered one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register address (bit 3 = channel) |
| reg_wr | input | 1 | Write strobe for reg_wdata at reg_addr |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| ext_clk | input | 2 | External count pin per channel |
| ext_rst | input | 2 | External clear pin per channel |
| irq_ovf | output | 2 | Wrap interrupt request per channel |
| irq_cma | output | 2 | Match-A interrupt request per channel |
| irq_cmb | output | 2 | Match-B interrupt request per channel |

## Verification
The assertions assume that the external pins are slow compared with the system clock. Each pin level must be held for several cycles, so that the synchronizer yields one clean edge per transition, and reset must be held for at least one edge so that the edge detectors start from a known history. The stimulus changes pins and registers only on falling clock edges and holds each pin level for four cycles. It also waits out the synchronizer delay before reading counters. Prescaler rates are checked as counter differences over a whole number of periods, so the result does not depend on the prescaler phase.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int DW      = 8;
  localparam int AW      = 4;
  localparam int OFF_W   = 3;
  localparam int N_CH    = 2;
  localparam int N_TAPS  = 3;
  localparam int N_FLAGS = 3;

  localparam int FLAG_OVF = 0;
  localparam int FLAG_CMA = 1;
  localparam int FLAG_CMB = 2;

  localparam logic [OFF_W-1:0] OFF_CTRL = 3'd0;
  localparam logic [OFF_W-1:0] OFF_STAT = 3'd1;
  localparam logic [OFF_W-1:0] OFF_CMPA = 3'd2;
  localparam logic [OFF_W-1:0] OFF_CMPB = 3'd3;
  localparam logic [OFF_W-1:0] OFF_CNT  = 3'd4;

  localparam logic [DW-1:0] CMP_RESET = '1;

  typedef enum logic [2:0] {
    SRC_OFF      = 3'b000,
    SRC_DIV_LO   = 3'b001,
    SRC_DIV_MID  = 3'b010,
    SRC_DIV_HI   = 3'b011,
    SRC_LINK     = 3'b100,
    SRC_EXT_RISE = 3'b101,
    SRC_EXT_FALL = 3'b110,
    SRC_EXT_BOTH = 3'b111
  } src_e;

  typedef enum logic [1:0] {
    CLR_NEVER = 2'b00,
    CLR_ON_A  = 2'b01,
    CLR_ON_B  = 2'b10,
    CLR_ON_PIN = 2'b11
  } clr_e;

  typedef struct packed {
    logic ie_cmb;
    logic ie_cma;
    logic ie_ovf;
    clr_e clr;
    src_e src;
  } ctrl_t;
endpackage

// File: rtl/dtmr_prescaler.sv
module dtmr_prescaler import dtmr_pkg::*; #(
  parameter int TAP_LO  = 2,
  parameter int TAP_MID = 5,
  parameter int TAP_HI  = 12
) (
  input  logic              clk,
  input  logic              rst,
  output logic [N_TAPS-1:0] tick
);
  localparam int PW = TAP_HI + 1;

  function automatic int tap_bit(input int idx);
    case (idx)
      0:       return TAP_LO;
      1:       return TAP_MID;
      default: return TAP_HI;
    endcase
  endfunction

  logic [PW-1:0]     div_q;
  logic [N_TAPS-1:0] tap_now;
  logic [N_TAPS-1:0] tap_q;

  for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
    assign tap_now[t] = div_q[tap_bit(t)];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      tap_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
      tap_q <= tap_now;
    end
  end

  // falling transition of each tap bit gives a one-cycle enable
  assign tick = tap_q & ~tap_now;

  a_r3_tick_single_cycle: assert property (@(posedge clk) disable iff (rst)
    tick[0] |=> !tick[0]);
  a_r3_fast_tap_spacing: assert property (@(posedge clk) disable iff (rst)
    tick[1] |-> tick[0]);
endmodule

// File: rtl/dtmr_sync_edge.sv
module dtmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
  assign fall = ~sync_q[STAGES-1] & last_q;
endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel import dtmr_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_TAPS-1:0]  tick,
  input  logic               link_in,
  input  logic               ext_clk,
  input  logic               ext_rst,
  input  logic               wr_ctrl,
  input  logic               wr_stat,
  input  logic               wr_cmpa,
  input  logic               wr_cmpb,
  input  logic               wr_cnt,
  input  logic [DW-1:0]      wdata,
  output ctrl_t              ctrl,
  output logic [N_FLAGS-1:0] flags,
  output logic [DW-1:0]      cmpa,
  output logic [DW-1:0]      cmpb,
  output logic [DW-1:0]      cnt,
  output logic               cma_evt,
  output logic               ovf_evt,
  output logic [N_FLAGS-1:0] irq
);
  logic clk_rise, clk_fall, pin_clr, unused_pin_fall;
  logic step, clear_now, eqa_q, eqb_q, eqa, eqb, cmb_evt;
  logic [N_FLAGS-1:0] keep, set_v;

  dtmr_sync_edge #(.STAGES(SYNC_STAGES)) u_clk_sync (
    .clk(clk), .rst(rst), .pin(ext_clk), .rise(clk_rise), .fall(clk_fall));

  dtmr_sync_edge #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(clk), .rst(rst), .pin(ext_rst), .rise(pin_clr), .fall(unused_pin_fall));

  always_comb begin
    case (ctrl.src)
      SRC_OFF:      step = 1'b0;
      SRC_DIV_LO:   step = tick[0];
      SRC_DIV_MID:  step = tick[1];
      SRC_DIV_HI:   step = tick[2];
      SRC_LINK:     step = link_in;
      SRC_EXT_RISE: step = clk_rise;
      SRC_EXT_FALL: step = clk_fall;
      SRC_EXT_BOTH: step = clk_rise | clk_fall;
      default:      step = 1'b0;
    endcase
  end

  assign eqa     = (cnt == cmpa);
  assign eqb     = (cnt == cmpb);
  assign cma_evt = eqa & ~eqa_q;
  assign cmb_evt = eqb & ~eqb_q;

  always_comb begin
    case (ctrl.clr)
      CLR_ON_A:   clear_now = cma_evt;
      CLR_ON_B:   clear_now = cmb_evt;
      CLR_ON_PIN: clear_now = pin_clr;
      default:    clear_now = 1'b0;
    endcase
  end

  assign ovf_evt = step & (&cnt) & ~clear_now & ~wr_cnt;

  always_comb begin
    set_v = '0;
    set_v[FLAG_OVF] = ovf_evt;
    set_v[FLAG_CMA] = cma_evt;
    set_v[FLAG_CMB] = cmb_evt;
  end
  assign keep = wr_stat ? wdata[N_FLAGS-1:0] : '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= '0;
      cmpa  <= CMP_RESET;
      cmpb  <= CMP_RESET;
      cnt   <= '0;
      eqa_q <= 1'b0;
      eqb_q <= 1'b0;
      flags <= '0;
      irq   <= '0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'(wdata);
      if (wr_cmpa) cmpa <= wdata;
      if (wr_cmpb) cmpb <= wdata;
      if (clear_now)   cnt <= '0;
      else if (wr_cnt) cnt <= wdata;
      else if (step)   cnt <= cnt + 1'b1;
      eqa_q <= eqa;
      eqb_q <= eqb;
      flags <= set_v | (flags & keep);
      irq   <= flags & {ctrl.ie_cmb, ctrl.ie_cma, ctrl.ie_ovf};
    end
  end

  a_r9_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clear_now |=> (cnt == '0));
  a_r2_source_off_holds: assert property (@(posedge clk) disable iff (rst)
    (ctrl.src == SRC_OFF && !clear_now && !wr_cnt) |=> $stable(cnt));
  a_r5_link_advances: assert property (@(posedge clk) disable iff (rst)
    (ctrl.src == SRC_LINK && link_in && !clear_now && !wr_cnt) |=> (cnt == $past(cnt) + 8'd1));
  a_r8_wrap_sets_flag: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> (flags[FLAG_OVF] && cnt == '0));
  a_r8_match_a_sets_flag: assert property (@(posedge clk) disable iff (rst)
    cma_evt |=> flags[FLAG_CMA]);
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (flags[FLAG_CMB] && !wr_stat) |=> flags[FLAG_CMB]);
  a_r10_irq_follows: assert property (@(posedge clk) disable iff (rst)
    (flags[FLAG_OVF] && ctrl.ie_ovf) |=> irq[FLAG_OVF]);
  a_r10_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    !flags[FLAG_CMA] |=> !irq[FLAG_CMA]);
endmodule

// File: rtl/dtmr_top.sv
module dtmr_top import dtmr_pkg::*; #(
  parameter int TAP_LO      = 2,
  parameter int TAP_MID     = 5,
  parameter int TAP_HI      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   reg_addr,
  input  logic            reg_wr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [N_CH-1:0] ext_clk,
  input  logic [N_CH-1:0] ext_rst,
  output logic [N_CH-1:0] irq_ovf,
  output logic [N_CH-1:0] irq_cma,
  output logic [N_CH-1:0] irq_cmb
);
  logic [N_TAPS-1:0]  tick;
  ctrl_t              ctrl_w  [N_CH];
  logic [N_FLAGS-1:0] flags_w [N_CH];
  logic [N_FLAGS-1:0] irq_w   [N_CH];
  logic [DW-1:0]      cmpa_w  [N_CH];
  logic [DW-1:0]      cmpb_w  [N_CH];
  logic [DW-1:0]      cnt_w   [N_CH];
  logic [N_CH-1:0]    cma_evt_w, ovf_evt_w, link_q, link_in;
  logic               both_linked, unused_evt;
  logic [OFF_W-1:0]   off;
  logic               sel;

  assign off = reg_addr[OFF_W-1:0];
  assign sel = reg_addr[AW-1];

  dtmr_prescaler #(.TAP_LO(TAP_LO), .TAP_MID(TAP_MID), .TAP_HI(TAP_HI)) u_pre (
    .clk(clk), .rst(rst), .tick(tick));

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic hit;
    assign hit = reg_wr && (int'(sel) == c);

    dtmr_channel #(.SYNC_STAGES(SYNC_STAGES)) u_ch (
      .clk(clk), .rst(rst), .tick(tick), .link_in(link_in[c]),
      .ext_clk(ext_clk[c]), .ext_rst(ext_rst[c]),
      .wr_ctrl(hit && off == OFF_CTRL), .wr_stat(hit && off == OFF_STAT),
      .wr_cmpa(hit && off == OFF_CMPA), .wr_cmpb(hit && off == OFF_CMPB),
      .wr_cnt(hit && off == OFF_CNT), .wdata(reg_wdata),
      .ctrl(ctrl_w[c]), .flags(flags_w[c]), .cmpa(cmpa_w[c]), .cmpb(cmpb_w[c]),
      .cnt(cnt_w[c]), .cma_evt(cma_evt_w[c]), .ovf_evt(ovf_evt_w[c]), .irq(irq_w[c]));

    assign irq_ovf[c] = irq_w[c][FLAG_OVF];
    assign irq_cma[c] = irq_w[c][FLAG_CMA];
    assign irq_cmb[c] = irq_w[c][FLAG_CMB];
  end

  // cross link: channel 0 takes channel 1 wraps, channel 1 takes channel 0 match A
  assign unused_evt  = ovf_evt_w[0] | cma_evt_w[1];
  assign both_linked = (ctrl_w[0].src == SRC_LINK) && (ctrl_w[1].src == SRC_LINK);
  assign link_in     = both_linked ? '0 : link_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      link_q    <= '0;
      reg_rdata <= '0;
    end else begin
      link_q <= {cma_evt_w[0], ovf_evt_w[1]};
      case (off)
        OFF_CTRL: reg_rdata <= ctrl_w[sel];
        OFF_STAT: reg_rdata <= DW'(flags_w[sel]);
        OFF_CMPA: reg_rdata <= cmpa_w[sel];
        OFF_CMPB: reg_rdata <= cmpb_w[sel];
        OFF_CNT:  reg_rdata <= cnt_w[sel];
        default:  reg_rdata <= '0;
      endcase
    end
  end

  a_r6_no_link_when_both: assert property (@(posedge clk) disable iff (rst)
    (both_linked && !(reg_wr && off == OFF_CNT) && ctrl_w[1].clr == CLR_NEVER
     && ctrl_w[0].clr == CLR_NEVER) |=> $stable(cnt_w[1]));
  a_r5_wrap_reaches_ch0: assert property (@(posedge clk) disable iff (rst)
    (ovf_evt_w[1] && !both_linked) |=> link_q[0]);
endmodule

// File: tb/tb_dtmr_top.sv
module tb_dtmr_top;
  import dtmr_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] ext_clk = '0;
  logic [1:0] ext_rst = '0;
  logic [1:0] irq_ovf, irq_cma, irq_cmb;
  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  dtmr_top dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_clk(ext_clk),
    .ext_rst(ext_rst), .irq_ovf(irq_ovf), .irq_cma(irq_cma), .irq_cmb(irq_cmb));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int ch, input int off, input logic [7:0] d);
    @(negedge clk);
    reg_addr  = {ch[0], off[2:0]};
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input int ch, input int off, output logic [7:0] d);
    @(negedge clk);
    reg_addr = {ch[0], off[2:0]};
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic clk_pulses(input int ch, input int n);
    for (int i = 0; i < n; i++) begin
      ext_clk[ch] = 1'b1;
      idle(4);
      ext_clk[ch] = 1'b0;
      idle(4);
    end
    idle(6);
  endtask

  task automatic rst_pulse(input int ch);
    ext_rst[ch] = 1'b1;
    idle(4);
    ext_rst[ch] = 1'b0;
    idle(6);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v, a, b;
    idle(5);
    rst = 1'b0;
    idle(2);

    // R1: reset values and unmapped offsets
    for (int ch = 0; ch < 2; ch++) begin
      rd(ch, OFF_CTRL, v); check("R1 ctrl reset", v, 8'h00);
      rd(ch, OFF_STAT, v); check("R1 status reset", v, 8'h00);
      rd(ch, OFF_CMPA, v); check("R1 cmpa reset", v, 8'hFF);
      rd(ch, OFF_CMPB, v); check("R1 cmpb reset", v, 8'hFF);
      rd(ch, OFF_CNT, v);  check("R1 counter reset", v, 8'h00);
      for (int o = 5; o < 8; o++) begin
        rd(ch, o, v); check("R1 unmapped reads zero", v, 8'h00);
      end
    end

    // R1 R2: every control value reads back
    for (int ch = 0; ch < 2; ch++)
      for (int x = 0; x < 256; x++) begin
        wr(ch, OFF_CTRL, 8'(x));
        rd(ch, OFF_CTRL, v);
        check("R2 ctrl readback", v, 8'(x));
      end
    for (int ch = 0; ch < 2; ch++) begin
      wr(ch, OFF_CTRL, 8'h00);
      wr(ch, OFF_CNT, 8'h00);
      wr(ch, OFF_STAT, 8'h00);
    end

    // R2: source off holds the counter
    wr(0, OFF_CNT, 8'h33);
    rd(0, OFF_CNT, a); idle(100); rd(0, OFF_CNT, b);
    check("R2 source off holds", b, 8'h33);
    check("R2 source off no change", b - a, 8'h00);

    // R3: prescaler rates over two periods
    for (int ch = 0; ch < 2; ch++) begin
      wr(ch, OFF_CTRL, 8'h01);
      rd(ch, OFF_CNT, a); idle(16 - 2); rd(ch, OFF_CNT, b);
      check("R3 div8 rate", b - a, 8'd2);
      wr(ch, OFF_CTRL, 8'h02);
      rd(ch, OFF_CNT, a); idle(128 - 2); rd(ch, OFF_CNT, b);
      check("R3 div64 rate", b - a, 8'd2);
      wr(ch, OFF_CTRL, 8'h00);
    end
    wr(0, OFF_CTRL, 8'h03);
    rd(0, OFF_CNT, a); idle(16384 - 2); rd(0, OFF_CNT, b);
    check("R3 div8192 rate", b - a, 8'd2);
    wr(0, OFF_CTRL, 8'h00);

    // R4: external edge modes
    for (int ch = 0; ch < 2; ch++) begin
      wr(ch, OFF_CTRL, 8'h05);
      rd(ch, OFF_CNT, a); clk_pulses(ch, 5); rd(ch, OFF_CNT, b);
      check("R4 rising edges", b - a, 8'd5);
      wr(ch, OFF_CTRL, 8'h06);
      rd(ch, OFF_CNT, a); clk_pulses(ch, 3); rd(ch, OFF_CNT, b);
      check("R4 falling edges", b - a, 8'd3);
      wr(ch, OFF_CTRL, 8'h07);
      rd(ch, OFF_CNT, a); clk_pulses(ch, 4); rd(ch, OFF_CNT, b);
      check("R4 both edges", b - a, 8'd8);
      wr(ch, OFF_CTRL, 8'h00);
    end

    // R5 R7: channel 1 counts channel 0 match A, channel 0 clears on match A
    wr(0, OFF_CMPA, 8'h03);
    wr(0, OFF_CNT, 8'h00);
    wr(1, OFF_CNT, 8'h00);
    wr(1, OFF_CTRL, 8'h04);
    wr(0, OFF_STAT, 8'h00);
    wr(0, OFF_CTRL, 8'h0D);
    clk_pulses(0, 8);
    rd(0, OFF_CNT, v); check("R7 clear on match A", v, 8'h02);
    rd(1, OFF_CNT, v); check("R5 ch1 counts ch0 match A", v, 8'h02);
    rd(0, OFF_STAT, v); check("R8 match A flag", v & 8'h02, 8'h02);

    // R5: channel 0 counts channel 1 wraps
    wr(0, OFF_CTRL, 8'h00);
    wr(1, OFF_CTRL, 8'h00);
    wr(1, OFF_CNT, 8'hFE);
    wr(0, OFF_CNT, 8'h10);
    wr(1, OFF_STAT, 8'h00);
    wr(0, OFF_CTRL, 8'h04);
    wr(1, OFF_CTRL, 8'h05);
    clk_pulses(1, 2);
    rd(1, OFF_CNT, v); check("R8 ch1 wraps to zero", v, 8'h00);
    rd(0, OFF_CNT, v); check("R5 ch0 counts ch1 wrap", v, 8'h11);
    rd(1, OFF_STAT, v); check("R8 wrap and match flags", v, 8'h07);

    // R6: both linked, a write-created match must not reach channel 1
    wr(1, OFF_CTRL, 8'h04);
    wr(0, OFF_STAT, 8'h00);
    wr(0, OFF_CMPA, 8'h11);
    idle(10);
    rd(1, OFF_CNT, v); check("R6 ch1 receives no pulse", v, 8'h00);
    rd(0, OFF_CNT, v); check("R6 ch0 receives no pulse", v, 8'h11);
    rd(0, OFF_STAT, v); check("R8 write-made match sets flag", v & 8'h02, 8'h02);
    wr(0, OFF_CTRL, 8'h00);
    wr(1, OFF_CTRL, 8'h00);

    // R7: clear on match B
    wr(0, OFF_CMPA, 8'hFF);
    wr(0, OFF_CMPB, 8'h02);
    wr(0, OFF_CNT, 8'h00);
    wr(0, OFF_CTRL, 8'h15);
    clk_pulses(0, 3);
    rd(0, OFF_CNT, v); check("R7 clear on match B", v, 8'h01);
    wr(0, OFF_CTRL, 8'h00);

    // R7: pin clear only with select 11
    for (int ch = 0; ch < 2; ch++) begin
      wr(ch, OFF_CNT, 8'h40);
      rst_pulse(ch);
      rd(ch, OFF_CNT, v); check("R7 pin ignored with select 00", v, 8'h40);
      wr(ch, OFF_CTRL, 8'h18);
      rst_pulse(ch);
      rd(ch, OFF_CNT, v); check("R7 pin clear", v, 8'h00);
      wr(ch, OFF_CTRL, 8'h00);
    end

    // R9: clear and count in the same cycle
    wr(0, OFF_CNT, 8'h40);
    wr(0, OFF_CTRL, 8'h1F);
    @(negedge clk);
    ext_clk[0] = 1'b1;
    ext_rst[0] = 1'b1;
    idle(6);
    rd(0, OFF_CNT, v); check("R9 clear beats count", v, 8'h00);
    ext_clk[0] = 1'b0;
    ext_rst[0] = 1'b0;
    idle(6);
    rd(0, OFF_CNT, v); check("R9 later edge counts", v, 8'h01);
    wr(0, OFF_CTRL, 8'h00);

    // R8: write-zero clears, write-one ignored
    wr(0, OFF_STAT, 8'h00);
    rd(0, OFF_STAT, v); check("R8 status cleared", v, 8'h00);
    wr(0, OFF_CMPA, 8'h01);
    wr(0, OFF_CMPB, 8'h01);
    rd(0, OFF_STAT, v); check("R8 both match flags", v, 8'h06);
    wr(0, OFF_STAT, 8'h07);
    rd(0, OFF_STAT, v); check("R8 writing ones no effect", v, 8'h06);
    wr(0, OFF_STAT, 8'h02);
    rd(0, OFF_STAT, v); check("R8 selective clear", v, 8'h02);
    wr(0, OFF_STAT, 8'h00);

    // R10: set all three flags on channel 0, sweep enables
    wr(0, OFF_CMPA, 8'h80);
    wr(0, OFF_CMPB, 8'h80);
    wr(0, OFF_CNT, 8'h80);
    wr(0, OFF_CNT, 8'hFF);
    wr(0, OFF_CTRL, 8'h05);
    clk_pulses(0, 1);
    wr(0, OFF_CTRL, 8'h00);
    rd(0, OFF_STAT, v); check("R8 all flags set", v, 8'h07);
    wr(1, OFF_STAT, 8'h00);
    for (int e = 0; e < 8; e++) begin
      wr(0, OFF_CTRL, {3'(e), 5'b0});
      idle(2);
      check("R10 irq_ovf", {7'b0, irq_ovf[0]}, {7'b0, 1'(e)});
      check("R10 irq_cma", {7'b0, irq_cma[0]}, {7'b0, 1'(e >> 1)});
      check("R10 irq_cmb", {7'b0, irq_cmb[0]}, {7'b0, 1'(e >> 2)});
      check("R10 ch1 quiet", {5'b0, irq_ovf[1], irq_cma[1], irq_cmb[1]}, 8'h00);
    end
    wr(0, OFF_STAT, 8'h00);
    idle(2);
    check("R10 irqs drop with flags", {5'b0, irq_ovf[0], irq_cma[0], irq_cmb[0]}, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule